// File: doc/BRIEF.md
# Processor Status Word and Condition Flag Unit

This block keeps a 16-bit processor status word. The upper half is a privileged system byte: two trace enables, a supervisor bit and a 3-bit interrupt priority mask. The lower half is a user byte that holds five condition flags. When the ALU reports a result, the block derives the negative and zero flags from that result at the operand width of the operation. It takes the carry and overflow flags from the ALU's own indications. A per-operation mask selects which flags the operation may touch. The block does no arithmetic of its own.

Software writes reach the word through two requests: a full-word write and a low-byte write. The full-word write can change the system byte only while the supervisor bit is set. The supervisor bit also drives the stack-pointer select. The block compares a pending interrupt level against the mask to decide whether the request is accepted. Level 7 always gets through. At each instruction boundary the block raises a trace request when the trace enables call for one.

Top module: `sr_flag_unit`

## Requirements
- R1: After reset the status word reads 0x2700: supervisor bit (bit 13) set, mask (bits 10..8) at 7, trace enables (bits 15, 14) clear, all flags clear.
- R2: On a flag update with the negative bit enabled, N (bit 3) takes bit 7 of the result for opSize 0 (byte), bit 15 for opSize 1 (word), and bit DATA_W-1 for opSize 2 (long).
- R3: On a flag update with the zero bit enabled, Z (bit 2) is set only when every bit of the result within the operand width is zero. Bits above that width are ignored.
- R4: flagMask enables updates per flag: bit 4 for X, 3 for N, 2 for Z, 1 for V, 0 for C. V (bit 1) takes ovfIn and C (bit 0) takes carryIn. Flags whose mask bit is clear keep their value.
- R5: When its mask bit is set, X (bit 4) takes carryIn if isArith is 1 and takes xIn otherwise.
- R6: A full-word write in supervisor mode loads bits 15, 14, 13, 10..8 and 4..0. Bits 12, 11 and 7..5 always read as zero.
- R7: A full-word write in user mode changes only the low byte. The system byte keeps its value.
- R8: A low-byte write changes only bits 7..0 in either mode. A write request in the same cycle as a flag update takes precedence, and the flag update is dropped.
- R9: supMode and spSel follow the supervisor bit. spSel = 1 selects the supervisor stack pointer and 0 selects the user stack pointer.
- R10: irqAccept is 1 when irqLevel is 7, or when irqLevel is numerically greater than the mask field. Otherwise it is 0.
- R11: traceReq is raised only while instrDone is 1. It is raised on every instruction when bit 15 is set, and only on instructions that have flowChange = 1 when bit 14 alone is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aluValid | input | 1 | Apply a flag update from the current ALU result |
| resultVal | input | DATA_W | ALU result value |
| opSize | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| carryIn | input | 1 | Carry out or borrow from the ALU |
| ovfIn | input | 1 | Signed overflow from the ALU |
| isArith | input | 1 | Operation is arithmetic (X follows carry) |
| xIn | input | 1 | Explicit X value for non-arithmetic operations |
| flagMask | input | 5 | Per-flag update enables {X,N,Z,V,C} |
| wrFull | input | 1 | Full-word write request |
| wrLow | input | 1 | Low-byte write request |
| wrData | input | 16 | Write data |
| instrDone | input | 1 | An instruction completes this cycle |
| flowChange | input | 1 | The completing instruction changed program flow |
| irqLevel | input | 3 | Pending interrupt level, 0 means none |
| srWord | output | 16 | Current status word |
| supMode | output | 1 | Supervisor bit |
| spSel | output | 1 | Stack pointer select, 1 = supervisor |
| traceReq | output | 1 | Trace exception request |
| irqAccept | output | 1 | Pending interrupt is accepted |

## Verification
The in-design properties assume that every input carries a defined 0 or 1 on each rising edge after reset. They also assume that an ALU update and a write request are legal inputs in the same cycle, with the write winning. The stimulus meets these assumptions: it drives every input to a known value from time zero and changes inputs only on falling edges. It enters user mode only by writing a word with bit 13 clear, and it returns to supervisor mode only through reset. That matches the rule that user code cannot touch the system byte.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int SR_W    = 16;
  localparam int BIT_T1  = 15;
  localparam int BIT_T0  = 14;
  localparam int BIT_S   = 13;
  localparam int MASK_HI = 10;
  localparam int MASK_LO = 8;
  localparam int IRQ_W   = MASK_HI - MASK_LO + 1;
  localparam int FLAG_W  = 5;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 16;

  localparam logic [SR_W-1:0] SR_LIVE  = 16'hE71F;
  localparam logic [SR_W-1:0] SR_RESET = 16'h2700;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } opSize_e;

  typedef struct packed {
    logic loadSys;
    logic loadUser;
    logic loadFlags;
  } srStrobe_t;
endpackage

// File: rtl/sr_datapath.sv
module sr_datapath
  import sr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  srStrobe_t         strobe,
  input  logic [SR_W-1:0]   wrData,
  input  logic [DATA_W-1:0] resultVal,
  input  logic [1:0]        opSize,
  input  logic              carryIn,
  input  logic              ovfIn,
  input  logic              isArith,
  input  logic              xIn,
  input  logic [FLAG_W-1:0] flagMask,
  output logic [SR_W-1:0]   srQ
);
  localparam int TOP = DATA_W - 1;

  logic              sizedNeg;
  logic              sizedZero;
  logic              xNew;
  logic [FLAG_W-1:0] flagCalc;
  logic [FLAG_W-1:0] flagNext;
  logic [SR_W-1:0]   srNext;

  always_comb begin
    case (opSize_e'(opSize))
      SZ_BYTE: begin
        sizedNeg  = resultVal[BYTE_W-1];
        sizedZero = ~|resultVal[BYTE_W-1:0];
      end
      SZ_WORD: begin
        sizedNeg  = resultVal[WORD_W-1];
        sizedZero = ~|resultVal[WORD_W-1:0];
      end
      default: begin
        sizedNeg  = resultVal[TOP];
        sizedZero = ~|resultVal;
      end
    endcase
  end

  always_comb begin
    xNew     = isArith ? carryIn : xIn;
    flagCalc = {xNew, sizedNeg, sizedZero, ovfIn, carryIn};
    flagNext = (flagCalc & flagMask) | (srQ[FLAG_W-1:0] & ~flagMask);
  end

  always_comb begin
    srNext = srQ;
    if (strobe.loadSys)
      srNext[SR_W-1:BYTE_W] = wrData[SR_W-1:BYTE_W];
    if (strobe.loadUser)
      srNext[BYTE_W-1:0] = wrData[BYTE_W-1:0];
    else if (strobe.loadFlags)
      srNext[FLAG_W-1:0] = flagNext;
    srNext = srNext & SR_LIVE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) srQ <= SR_RESET;
    else       srQ <= srNext;
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (srQ & ~SR_LIVE) == '0); // R6

  AST_USER_SYS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !srQ[BIT_S] |=> $stable(srQ[SR_W-1:BYTE_W])); // R7

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadFlags && !strobe.loadUser) |=> $stable(srQ[FLAG_W-1:0])); // R4

  AST_NZ_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadFlags && flagMask[3] && flagMask[2]) |=> !(srQ[3] && srQ[2])); // R2
endmodule

// File: rtl/sr_control.sv
module sr_control
  import sr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             aluValid,
  input  logic             wrFull,
  input  logic             wrLow,
  input  logic [SR_W-1:0]  srQ,
  input  logic             instrDone,
  input  logic             flowChange,
  input  logic [IRQ_W-1:0] irqLevel,
  output srStrobe_t        strobe,
  output logic             traceReq,
  output logic             irqAccept,
  output logic             spSel
);
  localparam logic [IRQ_W-1:0] NMI_LVL = IRQ_W'((1 << IRQ_W) - 1);

  logic             anyWrite;
  logic [IRQ_W-1:0] maskField;

  always_comb begin
    anyWrite         = wrFull | wrLow;
    strobe.loadUser  = anyWrite;
    strobe.loadSys   = wrFull & srQ[BIT_S];
    strobe.loadFlags = aluValid & ~anyWrite;
  end

  always_comb begin
    maskField = srQ[MASK_HI:MASK_LO];
    irqAccept = (irqLevel == NMI_LVL) || (irqLevel > maskField);
    traceReq  = instrDone & (srQ[BIT_T1] | (srQ[BIT_T0] & flowChange));
    spSel     = srQ[BIT_S];
  end

  AST_NMI_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == NMI_LVL) |-> irqAccept); // R10

  AST_TRACE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !instrDone |-> !traceReq); // R11
endmodule

// File: rtl/sr_flag_unit.sv
module sr_flag_unit
  import sr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aluValid,
  input  logic [DATA_W-1:0] resultVal,
  input  logic [1:0]        opSize,
  input  logic              carryIn,
  input  logic              ovfIn,
  input  logic              isArith,
  input  logic              xIn,
  input  logic [4:0]        flagMask,
  input  logic              wrFull,
  input  logic              wrLow,
  input  logic [15:0]       wrData,
  input  logic              instrDone,
  input  logic              flowChange,
  input  logic [2:0]        irqLevel,
  output logic [15:0]       srWord,
  output logic              supMode,
  output logic              spSel,
  output logic              traceReq,
  output logic              irqAccept
);
  srStrobe_t       strobe;
  logic [SR_W-1:0] srQ;

  sr_control u_ctrl (
    .clk(clk), .rstN(rstN), .aluValid(aluValid), .wrFull(wrFull),
    .wrLow(wrLow), .srQ(srQ), .instrDone(instrDone),
    .flowChange(flowChange), .irqLevel(irqLevel), .strobe(strobe),
    .traceReq(traceReq), .irqAccept(irqAccept), .spSel(spSel)
  );

  sr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .resultVal(resultVal), .opSize(opSize), .carryIn(carryIn),
    .ovfIn(ovfIn), .isArith(isArith), .xIn(xIn), .flagMask(flagMask),
    .srQ(srQ)
  );

  assign srWord  = srQ;
  assign supMode = srQ[BIT_S];
endmodule

// File: tb/sim_sr_flag_unit.sv
`timescale 1ns/1ps
module sim_sr_flag_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        aluValid = 1'b0;
  logic [31:0] resultVal = '0;
  logic [1:0]  opSize = 2'd2;
  logic        carryIn = 1'b0, ovfIn = 1'b0, isArith = 1'b0, xIn = 1'b0;
  logic [4:0]  flagMask = '0;
  logic        wrFull = 1'b0, wrLow = 1'b0;
  logic [15:0] wrData = '0;
  logic        instrDone = 1'b0, flowChange = 1'b0;
  logic [2:0]  irqLevel = '0;
  logic [15:0] srWord;
  logic        supMode, spSel, traceReq, irqAccept;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  sr_flag_unit u0 (
    .clk(clk), .rstN(rstN), .aluValid(aluValid), .resultVal(resultVal),
    .opSize(opSize), .carryIn(carryIn), .ovfIn(ovfIn), .isArith(isArith),
    .xIn(xIn), .flagMask(flagMask), .wrFull(wrFull), .wrLow(wrLow),
    .wrData(wrData), .instrDone(instrDone), .flowChange(flowChange),
    .irqLevel(irqLevel), .srWord(srWord), .supMode(supMode), .spSel(spSel),
    .traceReq(traceReq), .irqAccept(irqAccept)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic aluOp(input logic [31:0] res, input logic [1:0] sz, input logic c,
                       input logic v, input logic ar, input logic xi, input logic [4:0] m);
    @(negedge clk);
    resultVal = res; opSize = sz; carryIn = c; ovfIn = v; isArith = ar; xIn = xi;
    flagMask = m; aluValid = 1'b1;
    @(negedge clk);
    aluValid = 1'b0;
  endtask

  task automatic wrOp(input logic full, input logic [15:0] d);
    @(negedge clk);
    wrFull = full; wrLow = ~full; wrData = d;
    @(negedge clk);
    wrFull = 1'b0; wrLow = 1'b0;
  endtask

  task automatic tReset();
    doReset();
    chk("R1 reset word", srWord, 16'h2700);
    chk("R9 reset spSel", {15'd0, spSel}, 16'd1);
    chk("R9 reset supMode", {15'd0, supMode}, 16'd1);
  endtask

  task automatic tSizeNZ();
    doReset();
    aluOp(32'h0000_0080, 2'd0, 0, 0, 0, 0, 5'b01100);
    chk("R2 byte N", srWord, 16'h2708);
    aluOp(32'h0000_8000, 2'd0, 0, 0, 0, 0, 5'b01100);
    chk("R3 byte Z ignores upper", srWord, 16'h2704);
    aluOp(32'h0000_8000, 2'd1, 0, 0, 0, 0, 5'b01100);
    chk("R2 word N", srWord, 16'h2708);
    aluOp(32'h8000_0000, 2'd2, 0, 0, 0, 0, 5'b01100);
    chk("R2 long N", srWord, 16'h2708);
    aluOp(32'h0000_0000, 2'd2, 0, 0, 0, 0, 5'b01100);
    chk("R3 long Z", srWord, 16'h2704);
  endtask

  task automatic tMask();
    doReset();
    aluOp(32'd1, 2'd2, 1, 1, 1, 0, 5'b11111);
    chk("R4 all flags", srWord, 16'h2713);
    aluOp(32'd0, 2'd2, 0, 0, 1, 0, 5'b00100);
    chk("R4 only Z updates", srWord, 16'h2717);
  endtask

  task automatic tExtend();
    doReset();
    aluOp(32'd5, 2'd2, 0, 0, 0, 1, 5'b11111);
    chk("R5 X from xIn", srWord, 16'h2710);
    aluOp(32'd5, 2'd2, 0, 0, 1, 1, 5'b10001);
    chk("R5 X from carry clear", srWord, 16'h2700);
    aluOp(32'd5, 2'd2, 1, 0, 1, 0, 5'b10000);
    chk("R5 X from carry set, C held", srWord, 16'h2710);
  endtask

  task automatic tWrites();
    doReset();
    wrOp(1'b1, 16'hFFFF);
    chk("R6 sup full write", srWord, 16'hE71F);
    wrOp(1'b1, 16'h0000);
    chk("R6 leave supervisor", srWord, 16'h0000);
    chk("R9 user spSel", {15'd0, spSel}, 16'd0);
    wrOp(1'b1, 16'hA71F);
    chk("R7 user full write", srWord, 16'h001F);
    wrOp(1'b0, 16'h3F0A);
    chk("R8 user low write", srWord, 16'h000A);
    doReset();
    wrOp(1'b0, 16'hFF05);
    chk("R8 sup low write", srWord, 16'h2705);
  endtask

  task automatic tPriority();
    doReset();
    @(negedge clk);
    resultVal = '0; opSize = 2'd2; carryIn = 0; ovfIn = 0; isArith = 0; xIn = 0;
    flagMask = 5'b11111; aluValid = 1'b1; wrLow = 1'b1; wrData = 16'h0001;
    @(negedge clk);
    aluValid = 1'b0; wrLow = 1'b0;
    chk("R8 write beats update", srWord, 16'h2701);
  endtask

  task automatic irqChk(input logic [2:0] lvl, input logic exp);
    @(negedge clk); irqLevel = lvl; #1;
    chk("R10 irq", {15'd0, irqAccept}, {15'd0, exp});
  endtask

  task automatic tIrq();
    doReset();
    irqChk(3'd6, 0); irqChk(3'd7, 1); irqChk(3'd0, 0);
    wrOp(1'b1, 16'h2300);
    irqChk(3'd3, 0); irqChk(3'd4, 1); irqChk(3'd7, 1);
    wrOp(1'b1, 16'h2000);
    irqChk(3'd0, 0); irqChk(3'd1, 1);
    irqLevel = 3'd0;
  endtask

  task automatic trChk(input logic d, input logic f, input logic exp);
    @(negedge clk); instrDone = d; flowChange = f; #1;
    chk("R11 trace", {15'd0, traceReq}, {15'd0, exp});
  endtask

  task automatic tTrace();
    doReset();
    trChk(1, 1, 0);
    wrOp(1'b1, 16'hA000);
    trChk(1, 0, 1); trChk(0, 1, 0);
    wrOp(1'b1, 16'h6000);
    trChk(1, 0, 0); trChk(1, 1, 1);
    wrOp(1'b1, 16'h2000);
    trChk(1, 1, 0);
    instrDone = 0; flowChange = 0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    tReset();
    tSizeNZ();
    tMask();
    tExtend();
    tWrites();
    tPriority();
    tIrq();
    tTrace();
    finishRun();
  end
endmodule